// File: doc/BRIEF.md
# Quarter-Cycle Chip-Select Strobe Sequencer

This block shapes the memory strobes of one external bus access: an active-low chip select, an active-low write/byte enable, an active-low output enable, a bus-cycle-wide termination acknowledge and an active-low burst-in-progress indicator. It runs on a clock four times the bus clock, so each strobe edge lands on a quarter of a bus cycle (a "tick" below). An access starts when a request (direction, region number, burst flag) is accepted together with that region's timing settings, which are captured at acceptance and held for the whole access.

The settings are a wait-state count W, a burst-beat wait-state count B, a relaxed-timing switch, a 2-bit select-delay code, an early-negate switch, an external-termination switch, an extended-hold switch and a late-burst-indicator switch. Relaxed timing doubles W and B and moves edges by whole bus cycles. Extended hold puts one idle bus cycle (4 ticks, all strobes inactive) between a read and a following access that could collide with it on the bus.

Tick 0 of an access is the first clock cycle after the acceptance edge (or after the idle bus cycle, when one is inserted). All outputs are registered and show, in each cycle, the state of the tick that cycle represents. The acknowledge and burst-indicator positions below are relative to beats: beat 0 lasts the single-access length, every later beat lasts 4*(1+B') ticks, where B' is B (doubled when relaxed).

Top module: `chip_select_timer`

## Requirements
- R1: While reset is high and after it, until the first request, cs_n, we_n, oe_n and burst_n are 1, ack is 0 and req_ready is 1.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1; req_ready is 0 from the next cycle until the cycle after the access's last tick, and all strobes are inactive whenever req_ready is 1.
- R3: cs_n goes low at tick 0 for delay code 00 or 01, tick 1 for code 10, tick 2 for code 11; with relaxed timing codes 10 and 11 add 4 ticks.
- R4: Reads drive only oe_n and writes only we_n; the driven one goes low at tick 3, or tick 7 with relaxed timing and delay code 10 or 11.
- R5: oe_n returns high for the last tick of the access; we_n returns high for the last 1 tick with early-negate off, the last 2 ticks with early-negate on, or the last 6 ticks with early-negate and relaxed timing both on.
- R6: cs_n returns high for the last tick, except a write with early-negate on and delay code 10/11, which uses the last 2 ticks (6 ticks when relaxed).
- R7: A single access lasts 4*C ticks with C = 2+W' plus one when relaxed and (code 10/11 or early-negated write), plus one more when relaxed, early-negated write and code 10/11; W' is W doubled when relaxed.
- R8: With the burst flag set and internal termination, the access has 4 beats: beat 0 of 4*C ticks, then three of 4*(1+B') ticks each, B' being B doubled when relaxed.
- R9: With internal termination, ack is 1 during the last 4 ticks of every beat and 0 elsewhere; with external termination ack stays 0.
- R10: With external termination W is taken as 0, the burst flag is ignored, C is at least 3 when relaxed, and the position counter waits at tick 4*C-4 (4*C-8 when relaxed) until ext_ack has been seen high in any cycle of the access.
- R11: If the previous access was a read with extended hold, and the new request is a write or a read to another region, 4 idle ticks precede tick 0.
- R12: For an internal-termination burst, burst_n is 0 from tick 0 (or from tick 4*W' with late mode on) until the last beat starts; otherwise it stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Idle, a request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | RID_W | Region number of the request |
| req_burst | input | 1 | Request is a 4-beat burst |
| cfg_wait | input | WS_W | Wait-state count W |
| cfg_bwait | input | WS_W | Burst-beat wait-state count B |
| cfg_relax | input | 1 | Relaxed timing |
| cfg_csdly | input | 2 | Select-delay code |
| cfg_early | input | 1 | Early negate of write strobe |
| cfg_ext | input | 1 | External termination |
| cfg_hold | input | 1 | Extended hold after reads |
| cfg_late | input | 1 | Late burst indicator |
| ext_ack | input | 1 | External termination acknowledge |
| cs_n | output | 1 | Chip select, active low |
| we_n | output | 1 | Write/byte enable, active low |
| oe_n | output | 1 | Output enable, active low |
| ack | output | 1 | Beat termination acknowledge |
| burst_n | output | 1 | Burst in progress, active low |

## Verification
Every output is due in the very cycle that represents its tick: an acceptance edge is followed directly by tick 0, and an inserted idle bus cycle shifts everything by exactly 4 cycles. The bench keeps its own tick position per access, advanced on the same clock edge as the design, and compares all six outputs half a cycle later, so each edge position in R3 to R12 is checked in the exact tick it is owed and an off-by-one in either direction shows up. External-termination runs release ext_ack both before and after the wait point to check the hold and the relaxed minimum length.

// File: rtl/cst_pkg.sv
package cst_pkg;
    parameter int WS_W  = 4;
    parameter int RID_W = 3;
    parameter int BEATS = 4;

    localparam int WS_MAX    = (1 << WS_W) - 1;
    localparam int MAX_TICKS = 4 * (4 + 2 * WS_MAX) + (BEATS - 1) * 4 * (1 + 2 * WS_MAX);
    localparam int POS_W     = $clog2(MAX_TICKS + 16);
    localparam int BEAT_W    = $clog2(BEATS) + 1;

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic [1:0] {PH_IDLE, PH_GAP, PH_RUN} phase_e;

    // Tick positions of one access, all fixed at acceptance.
    typedef struct packed {
        pos_t t1;        // length of beat 0
        pos_t blen;      // length of each later beat
        pos_t total;     // whole access
        pos_t cs_on;     // select assert tick
        pos_t st_on;     // read/write strobe assert tick
        pos_t cs_lead;   // ticks of select high before end
        pos_t we_lead;   // ticks of write strobe high before end
        pos_t bi_on;     // burst indicator assert tick
        pos_t stall_at;  // external-termination wait point
        logic wr;
        logic ext;
        logic multi;
    } shape_t;

    function automatic pos_t to_ticks(input pos_t cycles);
        return pos_t'(cycles << 2);
    endfunction
endpackage

// File: rtl/cst_timing.sv
module cst_timing
    import cst_pkg::*;
(
    input  logic            wr,
    input  logic            burst,
    input  logic [WS_W-1:0] wait_n,
    input  logic [WS_W-1:0] bwait_n,
    input  logic            relax,
    input  logic [1:0]      dly,
    input  logic            early,
    input  logic            ext,
    input  logic            late,
    output shape_t          shp
);
    logic nz;
    pos_t w, weff, bweff, cyc, t1, blen, total;

    always_comb begin
        nz    = dly[1];
        w     = ext ? '0 : pos_t'(wait_n);
        weff  = relax ? pos_t'(w << 1) : w;
        bweff = relax ? pos_t'(pos_t'(bwait_n) << 1) : pos_t'(bwait_n);

        cyc = pos_t'(2) + weff;
        if (relax && (nz || (wr && early))) cyc = cyc + pos_t'(1);
        if (relax && wr && early && nz)     cyc = cyc + pos_t'(1);
        if (ext && relax && cyc < pos_t'(3)) cyc = pos_t'(3);

        t1    = to_ticks(cyc);
        blen  = to_ticks(pos_t'(1) + bweff);
        total = (burst && !ext) ? t1 + pos_t'(BEATS - 1) * blen : t1;

        shp.t1    = t1;
        shp.blen  = blen;
        shp.total = total;
        shp.multi = burst && !ext;
        shp.wr    = wr;
        shp.ext   = ext;

        case (dly)
            2'b10:   shp.cs_on = pos_t'(1);
            2'b11:   shp.cs_on = pos_t'(2);
            default: shp.cs_on = '0;
        endcase
        if (relax && nz) shp.cs_on = shp.cs_on + pos_t'(4);

        shp.st_on    = (relax && nz) ? pos_t'(7) : pos_t'(3);
        shp.we_lead  = !early ? pos_t'(1) : (relax ? pos_t'(6) : pos_t'(2));
        shp.cs_lead  = (wr && early && nz) ? (relax ? pos_t'(6) : pos_t'(2)) : pos_t'(1);
        shp.bi_on    = late ? to_ticks(weff) : '0;
        shp.stall_at = relax ? total - pos_t'(8) : total - pos_t'(4);
    end
endmodule

// File: rtl/cst_seq.sv
module cst_seq
    import cst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [RID_W-1:0] req_region,
    input  logic             hold_cfg,
    input  logic             ext_ack,
    input  shape_t           shp_in,
    output logic             req_ready,
    output phase_e           n_phase,
    output pos_t             n_pos,
    output pos_t             n_bpos,
    output beat_t            n_beat,
    output shape_t           n_shp
);
    phase_e           ph_q, ph_d;
    pos_t             pos_q, pos_d, bpos_q, bpos_d, cur_len;
    beat_t            beat_q, beat_d;
    logic [1:0]       g_q, g_d;
    shape_t           shp_q, shp_d;
    logic             seen_q, prv_rd_q, prv_hold_q, hold_q;
    logic [RID_W-1:0] prv_reg_q, reg_q;
    logic             accept, hazard, stall, done;

    assign accept = (ph_q == PH_IDLE) && req_valid;
    assign hazard = prv_rd_q && prv_hold_q && (shp_in.wr || (req_region != prv_reg_q));

    always_comb begin
        ph_d    = ph_q;
        pos_d   = pos_q;
        bpos_d  = bpos_q;
        beat_d  = beat_q;
        g_d     = g_q;
        shp_d   = shp_q;
        stall   = 1'b0;
        done    = 1'b0;
        cur_len = (beat_q == '0) ? shp_q.t1 : shp_q.blen;
        case (ph_q)
            PH_IDLE: begin
                if (req_valid) begin
                    shp_d  = shp_in;
                    pos_d  = '0;
                    bpos_d = '0;
                    beat_d = '0;
                    g_d    = '0;
                    ph_d   = hazard ? PH_GAP : PH_RUN;
                end
            end
            PH_GAP: begin
                if (g_q == 2'd3) begin
                    ph_d   = PH_RUN;
                    pos_d  = '0;
                    bpos_d = '0;
                    beat_d = '0;
                end else begin
                    g_d = g_q + 2'd1;
                end
            end
            PH_RUN: begin
                stall = shp_q.ext && (pos_q == shp_q.stall_at) && !(seen_q || ext_ack);
                if (pos_q == shp_q.total - pos_t'(1)) begin
                    done = 1'b1;
                    ph_d = PH_IDLE;
                end else if (!stall) begin
                    pos_d = pos_q + pos_t'(1);
                    if (bpos_q == cur_len - pos_t'(1)) begin
                        bpos_d = '0;
                        beat_d = beat_q + beat_t'(1);
                    end else begin
                        bpos_d = bpos_q + pos_t'(1);
                    end
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q       <= PH_IDLE;
            pos_q      <= '0;
            bpos_q     <= '0;
            beat_q     <= '0;
            g_q        <= '0;
            shp_q      <= '0;
            seen_q     <= 1'b0;
            prv_rd_q   <= 1'b0;
            prv_hold_q <= 1'b0;
            prv_reg_q  <= '0;
            reg_q      <= '0;
            hold_q     <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            pos_q  <= pos_d;
            bpos_q <= bpos_d;
            beat_q <= beat_d;
            g_q    <= g_d;
            shp_q  <= shp_d;
            if (accept) begin
                reg_q  <= req_region;
                hold_q <= hold_cfg;
                seen_q <= 1'b0;
            end else if (ph_q == PH_RUN && ext_ack) begin
                seen_q <= 1'b1;
            end
            if (done) begin
                prv_rd_q   <= !shp_q.wr;
                prv_reg_q  <= reg_q;
                prv_hold_q <= hold_q;
            end
        end
    end

    assign req_ready = (ph_q == PH_IDLE);
    assign n_phase   = ph_d;
    assign n_pos     = pos_d;
    assign n_bpos    = bpos_d;
    assign n_beat    = beat_d;
    assign n_shp     = shp_d;
endmodule

// File: rtl/cst_drive.sv
module cst_drive
    import cst_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e n_phase,
    input  pos_t   n_pos,
    input  pos_t   n_bpos,
    input  beat_t  n_beat,
    input  shape_t n_shp,
    output logic   cs_n,
    output logic   we_n,
    output logic   oe_n,
    output logic   ack,
    output logic   burst_n
);
    logic run, cs_on, we_on, oe_on, ack_on, bi_on;
    pos_t blen;

    always_comb begin
        run   = (n_phase == PH_RUN);
        blen  = (n_beat == '0) ? n_shp.t1 : n_shp.blen;
        cs_on = run && (n_pos >= n_shp.cs_on) && (n_pos + n_shp.cs_lead < n_shp.total);
        oe_on = run && !n_shp.wr && (n_pos >= n_shp.st_on) && (n_pos + pos_t'(1) < n_shp.total);
        we_on = run && n_shp.wr && (n_pos >= n_shp.st_on) && (n_pos + n_shp.we_lead < n_shp.total);
        ack_on = run && !n_shp.ext && (n_bpos + pos_t'(4) >= blen);
        bi_on = run && n_shp.multi && (n_pos >= n_shp.bi_on) && (n_beat < beat_t'(BEATS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n    <= 1'b1;
            we_n    <= 1'b1;
            oe_n    <= 1'b1;
            ack     <= 1'b0;
            burst_n <= 1'b1;
        end else begin
            cs_n    <= !cs_on;
            we_n    <= !we_on;
            oe_n    <= !oe_on;
            ack     <= ack_on;
            burst_n <= !bi_on;
        end
    end
endmodule

// File: rtl/chip_select_timer.sv
module chip_select_timer
    import cst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [RID_W-1:0] req_region,
    input  logic             req_burst,
    input  logic [WS_W-1:0]  cfg_wait,
    input  logic [WS_W-1:0]  cfg_bwait,
    input  logic             cfg_relax,
    input  logic [1:0]       cfg_csdly,
    input  logic             cfg_early,
    input  logic             cfg_ext,
    input  logic             cfg_hold,
    input  logic             cfg_late,
    input  logic             ext_ack,
    output logic             cs_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             ack,
    output logic             burst_n
);
    shape_t shp_new, n_shp;
    phase_e n_phase;
    pos_t   n_pos, n_bpos;
    beat_t  n_beat;

    cst_timing u_timing (
        .wr(req_write), .burst(req_burst), .wait_n(cfg_wait), .bwait_n(cfg_bwait),
        .relax(cfg_relax), .dly(cfg_csdly), .early(cfg_early), .ext(cfg_ext),
        .late(cfg_late), .shp(shp_new)
    );

    cst_seq u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_region(req_region),
        .hold_cfg(cfg_hold), .ext_ack(ext_ack), .shp_in(shp_new),
        .req_ready(req_ready), .n_phase(n_phase), .n_pos(n_pos),
        .n_bpos(n_bpos), .n_beat(n_beat), .n_shp(n_shp)
    );

    cst_drive u_drive (
        .clk(clk), .rst(rst), .n_phase(n_phase), .n_pos(n_pos), .n_bpos(n_bpos),
        .n_beat(n_beat), .n_shp(n_shp), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .ack(ack), .burst_n(burst_n)
    );
endmodule

// File: rtl/cst_checker.sv
module cst_checker (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic cs_n,
    input logic we_n,
    input logic oe_n,
    input logic ack,
    input logic burst_n
);
    // R2: an idle block drives no strobe
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (cs_n && we_n && oe_n));

    // R2: a taken request makes the block busy on the next cycle
    p_take_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R4: read and write strobes never overlap
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !oe_n));

    // R6: read/write strobes sit inside the select window
    p_strobe_in_cs_r6: assert property (@(posedge clk) disable iff (rst)
        (!we_n || !oe_n) |-> !cs_n);

    // R9: acknowledge only during an access, wider than one tick
    p_ack_busy_r9: assert property (@(posedge clk) disable iff (rst)
        ack |-> !req_ready);
    p_ack_width_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |=> ack);

    // R12: burst indicator only during an access
    p_burst_busy_r12: assert property (@(posedge clk) disable iff (rst)
        !burst_n |-> !req_ready);
endmodule

bind chip_select_timer cst_checker u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .ack(ack), .burst_n(burst_n)
);

// File: tb/sim_chip_select_timer.sv
`timescale 1ns/1ps
module sim_chip_select_timer;
    import cst_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
    logic [RID_W-1:0] req_region = '0;
    logic [WS_W-1:0] cfg_wait = '0, cfg_bwait = '0;
    logic cfg_relax = 1'b0, cfg_early = 1'b0, cfg_ext = 1'b0, cfg_hold = 1'b0, cfg_late = 1'b0;
    logic [1:0] cfg_csdly = 2'b00;
    logic ext_ack = 1'b0;
    logic req_ready, cs_n, we_n, oe_n, ack, burst_n;

    always #2.5 clk = ~clk;

    chip_select_timer u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_region(req_region), .req_burst(req_burst),
        .cfg_wait(cfg_wait), .cfg_bwait(cfg_bwait), .cfg_relax(cfg_relax),
        .cfg_csdly(cfg_csdly), .cfg_early(cfg_early), .cfg_ext(cfg_ext),
        .cfg_hold(cfg_hold), .cfg_late(cfg_late), .ext_ack(ext_ack),
        .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .ack(ack), .burst_n(burst_n)
    );

    int nchk = 0, nfail = 0, cycles = 0;
    bit started = 0;

    // reference model state
    int m_st = 0, m_pos = 0, m_g = 0, m_seen = 0;
    int m_T = 0, m_T1 = 0, m_BL = 0, m_csa = 0, m_sta = 0, m_csl = 0, m_wel = 0;
    int m_ba = 0, m_S = 0, m_wr = 0, m_ext = 0, m_multi = 0, m_reg = 0, m_hold = 0;
    int p_rd = 0, p_reg = 0, p_hold = 0;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_st = 0; m_pos = 0; m_g = 0; m_seen = 0; p_rd = 0; p_reg = 0; p_hold = 0;
            m_T = 0;
        end else begin
            case (m_st)
                0: if (req_valid) begin
                    int w, we, bwe, nz, cyc;
                    w   = cfg_ext ? 0 : int'(cfg_wait);
                    we  = cfg_relax ? 2 * w : w;
                    bwe = cfg_relax ? 2 * int'(cfg_bwait) : int'(cfg_bwait);
                    nz  = (cfg_csdly >= 2) ? 1 : 0;
                    cyc = 2 + we;
                    if (cfg_relax && (nz == 1 || (req_write && cfg_early))) cyc++;
                    if (cfg_relax && req_write && cfg_early && nz == 1) cyc++;
                    if (cfg_ext && cfg_relax && cyc < 3) cyc = 3;
                    m_T1 = 4 * cyc;
                    m_BL = 4 * (1 + bwe);
                    m_multi = (req_burst && !cfg_ext) ? 1 : 0;
                    m_T = m_multi ? m_T1 + 3 * m_BL : m_T1;
                    m_csa = (cfg_csdly == 2'b10) ? 1 : (cfg_csdly == 2'b11) ? 2 : 0;
                    if (cfg_relax && nz == 1) m_csa += 4;
                    m_sta = (cfg_relax && nz == 1) ? 7 : 3;
                    m_wel = !cfg_early ? 1 : (cfg_relax ? 6 : 2);
                    m_csl = (req_write && cfg_early && nz == 1) ? (cfg_relax ? 6 : 2) : 1;
                    m_ba = cfg_late ? 4 * we : 0;
                    m_S = cfg_relax ? m_T - 8 : m_T - 4;
                    m_wr = req_write; m_ext = cfg_ext; m_reg = req_region; m_hold = cfg_hold;
                    m_seen = 0;
                    if (p_rd == 1 && p_hold == 1 && (req_write || int'(req_region) != p_reg)) begin
                        m_st = 1; m_g = 0;
                    end else begin
                        m_st = 2; m_pos = 0;
                    end
                end
                1: if (m_g == 3) begin m_st = 2; m_pos = 0; end else m_g++;
                default: begin
                    bit stall;
                    stall = (m_ext == 1) && (m_pos == m_S) && !(m_seen == 1 || ext_ack);
                    if (ext_ack) m_seen = 1;
                    if (m_pos == m_T - 1) begin
                        m_st = 0; p_rd = m_wr ? 0 : 1; p_reg = m_reg; p_hold = m_hold;
                    end else if (!stall) m_pos++;
                end
            endcase
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // compare every cycle, half a clock after the edge
    always @(negedge clk) begin
        if (started && !rst) begin
            bit run;
            logic e_cs, e_we, e_oe, e_ack, e_bn;
            int p, bl;
            run  = (m_st == 2);
            e_cs = !(run && m_pos >= m_csa && m_pos < m_T - m_csl);
            e_oe = !(run && !m_wr && m_pos >= m_sta && m_pos < m_T - 1);
            e_we = !(run && m_wr && m_pos >= m_sta && m_pos < m_T - m_wel);
            if (m_pos < m_T1) begin p = m_pos; bl = m_T1; end
            else begin p = (m_pos - m_T1) % m_BL; bl = m_BL; end
            e_ack = run && !m_ext && (p + 4 >= bl);
            e_bn  = !(run && m_multi && m_pos >= m_ba && m_pos < m_T - m_BL);
            chk("R3/R6/R7 cs_n", cs_n, e_cs);
            chk("R4/R5 oe_n", oe_n, e_oe);
            chk("R4/R5 we_n", we_n, e_we);
            chk("R9/R8/R10 ack", ack, e_ack);
            chk("R12 burst_n", burst_n, e_bn);
            chk("R2/R11 req_ready", req_ready, logic'(m_st == 0));
        end
    end

    task automatic access(input bit wr, input int rg, input bit bu, input int wt, input int bw,
                          input bit rx, input int dl, input bit en, input bit ex,
                          input bit hd, input bit lt, input int ackd);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_region = RID_W'(rg); req_burst = bu;
        cfg_wait = WS_W'(wt); cfg_bwait = WS_W'(bw); cfg_relax = rx; cfg_csdly = 2'(dl);
        cfg_early = en; cfg_ext = ex; cfg_hold = hd; cfg_late = lt;
        @(negedge clk);
        req_valid = 0;
        if (ex) begin
            repeat (ackd) @(negedge clk);
            ext_ack = 1;
            @(negedge clk);
            ext_ack = 0;
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1 cs_n", cs_n, 1'b1); chk("R1 we_n", we_n, 1'b1); chk("R1 oe_n", oe_n, 1'b1);
        chk("R1 ack", ack, 1'b0); chk("R1 burst_n", burst_n, 1'b1); chk("R1 ready", req_ready, 1'b1);
        rst = 0;
        @(negedge clk);
        // R3 R4 R5 R6 R7 basic reads/writes, normal timing
        access(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        access(0, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0);   // code 01 acts as 00
        access(1, 2, 0, 2, 0, 0, 2, 0, 0, 0, 0, 0);
        access(1, 2, 0, 1, 0, 0, 3, 1, 0, 0, 0, 0);   // early negate, code 11
        access(1, 3, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);   // early negate, code 00
        // relaxed timing variants (R7 lengths)
        access(0, 3, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0);
        access(0, 3, 0, 0, 0, 1, 3, 0, 0, 0, 0, 0);
        access(1, 4, 0, 1, 0, 1, 2, 1, 0, 0, 0, 0);
        access(1, 4, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0);
        access(1, 4, 0, 2, 0, 1, 2, 0, 0, 0, 0, 0);
        // R8 R12 bursts, including late indicator
        access(0, 5, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        access(0, 5, 1, 2, 0, 0, 2, 0, 0, 0, 1, 0);
        access(1, 5, 1, 2, 1, 1, 3, 1, 0, 0, 1, 0);
        // R10 external termination: late ack, early ack, relaxed minimum
        access(0, 6, 0, 5, 0, 0, 0, 0, 1, 0, 0, 12);
        access(1, 6, 1, 3, 0, 0, 2, 0, 1, 0, 0, 0);
        access(0, 6, 0, 0, 0, 1, 0, 0, 1, 0, 0, 1);
        access(0, 6, 0, 0, 0, 1, 0, 0, 1, 0, 0, 20);
        // R11 idle-cycle insertion after reads with extended hold
        access(0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        access(0, 2, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);   // other region: gap
        access(0, 2, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);   // same region: none
        access(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);   // write after read: gap
        access(1, 3, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);   // after a write: none
        access(0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);   // read, hold off
        access(1, 3, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);   // prior read had no hold
        while (!req_ready) @(negedge clk);
        repeat (8) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    always @(negedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule